// File: doc/BRIEF.md
# Video Processor Command Port Decoder

This block sits between a host bus and the memory side of a tile-based video processor. It turns control-port writes into register writes or access commands. It holds the current access address and access code. It steps that address after every data-port transfer. Two command formats exist. In the extended format (mode 5) a command takes two control words, and a pending flag marks that the second word is still due. In the legacy format (mode 4) every command is a single word, each step adds one extra count, and word-wide video-memory reads are turned into byte-wide reads.

The memory side signals `fetch_done` once it has prefetched a read value. Data writes are presented on a one-cycle queue output, which carries the address before the step and the code with its write bit set. Register writes leave the block as a one-cycle pulse with an index and a value. The register file, the memories and the transfer engine are not part of this block.

Top module: `vpcmd_decoder`

## Requirements
- R1: A control word taken as a first word with bits 15:14 equal to binary 10 is a register write. In the next cycle `reg_we` is high for exactly one clock, `reg_idx` equals bits 12:8 and `reg_val` equals bits 7:0.
- R2: Every first control word copies its bits 13:0 into address bits 13:0 and leaves address bits 15:14 unchanged.
- R3: On a first word with `mode5_en` high, code bits 5:2 are kept and code bits 1:0 take word bits 15:14. With `mode5_en` low, code bits 5:2 are cleared and code bits 1:0 take word bits 15:14.
- R4: In mode 5, a first word that is not a register write sets `cmd_pending`. While `cmd_pending` is high, a control word is a second word: address bits 15:14 take word bits 1:0, code bits 5:2 take word bits 7:4, `cmd_pending` clears, the prefetch flag clears, and no register write is made even if bits 15:14 are 10. In mode 4, `cmd_pending` is never set.
- R5: A control read clears `cmd_pending`. Any data-port read or write also clears it.
- R6: A data write adds `autoinc` to the address, plus one more when `mode5_en` is low, modulo 2^16. In the next cycle `wq_valid` pulses, `wq_addr` holds the address before the step, and `wq_code` holds the code with bit 0 forced to 1.
- R7: A data read clears code bit 0. The address steps as in R6 only if the prefetch flag is set, and the read clears that flag. `fetch_done` sets the flag only in a cycle with no port strobe. A mode-4 single-word command that is not a register write also clears the flag.
- R8: With `mode5_en` low, a code of 0x00 (word-wide video-memory read) becomes 0x0C (byte-wide video-memory read). This happens after a command write and after a data read.
- R9: Reset clears the address, the code, `cmd_pending`, the prefetch flag, `reg_we` and `wq_valid`.
- R10: Only one strobe is served per cycle, in the priority order control write, control read, data write, data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control word |
| ctl_rd | input | 1 | Control-port read strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| fetch_done | input | 1 | A prefetched read value is now present |
| mode5_en | input | 1 | High selects the extended mode, low the legacy mode |
| autoinc | input | 8 | Address step per data access |
| acc_addr | output | 16 | Current access address |
| acc_code | output | 6 | Current access code |
| cmd_pending | output | 1 | Second command word expected |
| reg_we | output | 1 | Register write pulse |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |
| wq_valid | output | 1 | Data write queued pulse |
| wq_addr | output | 16 | Address of the queued write |
| wq_code | output | 6 | Code of the queued write, bit 0 set |

## Verification
Every result is registered, so the address, the code, the pending flag and both pulses are due one clock after the edge that takes the strobe. The bench drives each strobe half a period before that edge. It removes the strobe and samples all outputs at the following falling edge, which is exactly one rising edge later. The pulse checks then wait one more cycle to confirm that the pulse has dropped. A prefetch indication is given its own idle cycle before the read that consumes it, so the read that steps the address and the read that does not are both observed.

// File: rtl/vpcmd_pkg.sv
package vpcmd_pkg;
  localparam int ADDR_W  = 16;
  localparam int CODE_W  = 6;
  localparam int WORD_W  = 16;
  localparam int LOW_W   = ADDR_W - 2;
  localparam int IDX_W   = 5;
  localparam int VAL_W   = 8;

  localparam logic [CODE_W-1:0] CODE_VRD_WORD = 6'h00;
  localparam logic [CODE_W-1:0] CODE_VRD_BYTE = 6'h0C;
  localparam logic [1:0]        TAG_REGWR     = 2'b10;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CTL_WR,
    OP_CTL_RD,
    OP_DAT_WR,
    OP_DAT_RD
  } op_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic              pend;
    logic              fetched;
  } acc_state_t;
endpackage

// File: rtl/vpcmd_code_fix.sv
module vpcmd_code_fix
  import vpcmd_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  input  logic              mode5,
  output logic [CODE_W-1:0] code_out
);
  always_comb begin
    code_out = code_in;
    if (!mode5 && code_in == CODE_VRD_WORD) code_out = CODE_VRD_BYTE;
  end
endmodule

// File: rtl/vpcmd_addr_step.sv
module vpcmd_addr_step
  import vpcmd_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [INC_W-1:0]  inc,
  input  logic              mode5,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] extra;

  always_comb begin
    extra    = mode5 ? '0 : ADDR_W'(1);
    addr_out = addr_in + ADDR_W'(inc) + extra;
  end
endmodule

// File: rtl/vpcmd_ctl_dec.sv
module vpcmd_ctl_dec
  import vpcmd_pkg::*;
(
  input  acc_state_t        cur,
  input  logic [WORD_W-1:0] word,
  input  logic              mode5,
  output acc_state_t        nxt,
  output logic              reg_hit,
  output logic [IDX_W-1:0]  idx,
  output logic [VAL_W-1:0]  val
);
  logic [CODE_W-1:0] first_code;
  logic [CODE_W-1:0] first_fixed;

  always_comb begin
    first_code = mode5 ? {cur.code[CODE_W-1:2], word[WORD_W-1 -: 2]}
                       : {{(CODE_W-2){1'b0}}, word[WORD_W-1 -: 2]};
  end

  vpcmd_code_fix u_fix (
    .code_in  (first_code),
    .mode5    (mode5),
    .code_out (first_fixed)
  );

  always_comb begin
    nxt     = cur;
    reg_hit = 1'b0;
    idx     = word[12:8];
    val     = word[VAL_W-1:0];
    if (cur.pend) begin
      nxt.addr[ADDR_W-1 -: 2]   = word[1:0];
      nxt.code[CODE_W-1:2]      = word[7:4];
      nxt.pend                  = 1'b0;
      nxt.fetched               = 1'b0;
    end else begin
      nxt.addr[LOW_W-1:0] = word[LOW_W-1:0];
      nxt.code            = first_fixed;
      if (word[WORD_W-1 -: 2] == TAG_REGWR) begin
        reg_hit = 1'b1;
      end else if (mode5) begin
        nxt.pend = 1'b1;
      end else begin
        nxt.fetched = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vpcmd_decoder.sv
module vpcmd_decoder
  import vpcmd_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              ctl_rd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              fetch_done,
  input  logic              mode5_en,
  input  logic [INC_W-1:0]  autoinc,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [CODE_W-1:0] acc_code,
  output logic              cmd_pending,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [VAL_W-1:0]  reg_val,
  output logic              wq_valid,
  output logic [ADDR_W-1:0] wq_addr,
  output logic [CODE_W-1:0] wq_code
);
  acc_state_t        st_q, st_d, dec_st;
  op_e               op;
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [VAL_W-1:0]  dec_val;
  logic [ADDR_W-1:0] step_addr;
  logic [CODE_W-1:0] rd_raw, rd_fixed;
  logic              reg_we_d, wq_valid_d;
  logic              fetched_q;

  always_comb begin
    if (ctl_wr)       op = OP_CTL_WR;
    else if (ctl_rd)  op = OP_CTL_RD;
    else if (data_wr) op = OP_DAT_WR;
    else if (data_rd) op = OP_DAT_RD;
    else              op = OP_IDLE;
  end

  vpcmd_ctl_dec u_dec (
    .cur     (st_q),
    .word    (ctl_wdata),
    .mode5   (mode5_en),
    .nxt     (dec_st),
    .reg_hit (dec_hit),
    .idx     (dec_idx),
    .val     (dec_val)
  );

  vpcmd_addr_step #(.INC_W(INC_W)) u_step (
    .addr_in  (st_q.addr),
    .inc      (autoinc),
    .mode5    (mode5_en),
    .addr_out (step_addr)
  );

  assign rd_raw = st_q.code & ~CODE_W'(1);

  vpcmd_code_fix u_rdfix (
    .code_in  (rd_raw),
    .mode5    (mode5_en),
    .code_out (rd_fixed)
  );

  always_comb begin
    st_d       = st_q;
    reg_we_d   = 1'b0;
    wq_valid_d = 1'b0;
    unique case (op)
      OP_CTL_WR: begin
        st_d     = dec_st;
        reg_we_d = dec_hit;
      end
      OP_CTL_RD: st_d.pend = 1'b0;
      OP_DAT_WR: begin
        st_d.pend  = 1'b0;
        st_d.addr  = step_addr;
        wq_valid_d = 1'b1;
      end
      OP_DAT_RD: begin
        st_d.pend    = 1'b0;
        st_d.code    = rd_fixed;
        st_d.fetched = 1'b0;
        if (st_q.fetched) st_d.addr = step_addr;
      end
      default: if (fetch_done) st_d.fetched = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      reg_we   <= 1'b0;
      wq_valid <= 1'b0;
    end else begin
      st_q     <= st_d;
      reg_we   <= reg_we_d;
      wq_valid <= wq_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_idx <= '0;
      reg_val <= '0;
    end else if (reg_we_d) begin
      reg_idx <= dec_idx;
      reg_val <= dec_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq_addr <= '0;
      wq_code <= '0;
    end else if (wq_valid_d) begin
      wq_addr <= st_q.addr;
      wq_code <= st_q.code | CODE_W'(1);
    end
  end

  assign acc_addr    = st_q.addr;
  assign acc_code    = st_q.code;
  assign cmd_pending = st_q.pend;
  assign fetched_q   = st_q.fetched;
endmodule

// File: rtl/vpcmd_decoder_chk.sv
module vpcmd_decoder_chk
  import vpcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic [WORD_W-1:0] ctl_wdata,
  input logic              ctl_rd,
  input logic              data_wr,
  input logic              data_rd,
  input logic              mode5_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [CODE_W-1:0] acc_code,
  input logic              cmd_pending,
  input logic              reg_we,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [VAL_W-1:0]  reg_val,
  input logic              wq_valid,
  input logic [ADDR_W-1:0] wq_addr,
  input logic [CODE_W-1:0] wq_code,
  input logic              fetched_q
);
  AST_REGWR_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !cmd_pending && ctl_wdata[15:14] == 2'b10 |=>
      reg_we && reg_idx == $past(ctl_wdata[12:8]) && reg_val == $past(ctl_wdata[7:0])); // R1

  AST_REGWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we || $past(ctl_wr)); // R1

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !cmd_pending |=>
      acc_addr[13:0] == $past(ctl_wdata[13:0]) && acc_addr[15:14] == $past(acc_addr[15:14])); // R2

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && cmd_pending |=>
      !reg_we && !cmd_pending && acc_addr[15:14] == $past(ctl_wdata[1:0])); // R4

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && (ctl_rd || data_wr || data_rd) |=> !cmd_pending); // R5

  AST_WQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !ctl_wr && !ctl_rd |=>
      wq_valid && wq_code[0] && wq_addr == $past(acc_addr)); // R6

  AST_RD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !ctl_wr && !ctl_rd && !data_wr && !fetched_q |=>
      $stable(acc_addr) && !acc_code[0]); // R7

  AST_M4_BYTE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !mode5_en |=> acc_code != 6'h00); // R8
endmodule

bind vpcmd_decoder vpcmd_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .ctl_rd      (ctl_rd),
  .data_wr     (data_wr),
  .data_rd     (data_rd),
  .mode5_en    (mode5_en),
  .acc_addr    (acc_addr),
  .acc_code    (acc_code),
  .cmd_pending (cmd_pending),
  .reg_we      (reg_we),
  .reg_idx     (reg_idx),
  .reg_val     (reg_val),
  .wq_valid    (wq_valid),
  .wq_addr     (wq_addr),
  .wq_code     (wq_code),
  .fetched_q   (fetched_q)
);

// File: tb/vpcmd_decoder_bench.sv
module vpcmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_rd = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic        fetch_done = 1'b0, mode5_en = 1'b1;
  logic [15:0] ctl_wdata = '0;
  logic [7:0]  autoinc = '0;
  logic [15:0] acc_addr, wq_addr;
  logic [5:0]  acc_code, wq_code;
  logic        cmd_pending, reg_we, wq_valid;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vpcmd_decoder u_vpcmd_decoder (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rd(ctl_rd), .data_wr(data_wr), .data_rd(data_rd),
    .fetch_done(fetch_done), .mode5_en(mode5_en), .autoinc(autoinc),
    .acc_addr(acc_addr), .acc_code(acc_code), .cmd_pending(cmd_pending),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val),
    .wq_valid(wq_valid), .wq_addr(wq_addr), .wq_code(wq_code)
  );

  // op: 0 control write, 1 control read, 2 data write, 3 data read, 4 prefetch
  // fields: op, word, mode5, autoinc, expected addr, expected code, expected pending
  localparam int NV = 29;
  localparam logic [50:0] TBL [NV] = '{
    {3'd0, 16'h4123, 1'b1, 8'h00, 16'h0123, 6'h01, 1'b1},
    {3'd0, 16'h0092, 1'b1, 8'h00, 16'h8123, 6'h25, 1'b0},
    {3'd2, 16'h0000, 1'b1, 8'h02, 16'h8125, 6'h25, 1'b0},
    {3'd2, 16'h0000, 1'b1, 8'h80, 16'h81A5, 6'h25, 1'b0},
    {3'd0, 16'h8F12, 1'b1, 8'h00, 16'h8F12, 6'h26, 1'b0},
    {3'd0, 16'h7FFF, 1'b1, 8'h00, 16'hBFFF, 6'h25, 1'b1},
    {3'd1, 16'h0000, 1'b1, 8'h00, 16'hBFFF, 6'h25, 1'b0},
    {3'd0, 16'hC000, 1'b1, 8'h00, 16'h8000, 6'h27, 1'b1},
    {3'd0, 16'h0003, 1'b1, 8'h00, 16'hC000, 6'h03, 1'b0},
    {3'd2, 16'h0000, 1'b1, 8'hFF, 16'hC0FF, 6'h03, 1'b0},
    {3'd0, 16'h7FF0, 1'b1, 8'h00, 16'hFFF0, 6'h01, 1'b1},
    {3'd0, 16'h0003, 1'b1, 8'h00, 16'hFFF0, 6'h01, 1'b0},
    {3'd2, 16'h0000, 1'b1, 8'h20, 16'h0010, 6'h01, 1'b0},
    {3'd3, 16'h0000, 1'b1, 8'h04, 16'h0010, 6'h00, 1'b0},
    {3'd4, 16'h0000, 1'b1, 8'h04, 16'h0010, 6'h00, 1'b0},
    {3'd3, 16'h0000, 1'b1, 8'h04, 16'h0014, 6'h00, 1'b0},
    {3'd3, 16'h0000, 1'b1, 8'h04, 16'h0014, 6'h00, 1'b0},
    {3'd0, 16'h0100, 1'b0, 8'h00, 16'h0100, 6'h0C, 1'b0},
    {3'd2, 16'h0000, 1'b0, 8'h01, 16'h0102, 6'h0C, 1'b0},
    {3'd0, 16'h4200, 1'b0, 8'h00, 16'h0200, 6'h01, 1'b0},
    {3'd0, 16'h4300, 1'b0, 8'h00, 16'h0300, 6'h01, 1'b0},
    {3'd2, 16'h0000, 1'b0, 8'h00, 16'h0301, 6'h01, 1'b0},
    {3'd3, 16'h0000, 1'b0, 8'h02, 16'h0301, 6'h0C, 1'b0},
    {3'd4, 16'h0000, 1'b0, 8'h02, 16'h0301, 6'h0C, 1'b0},
    {3'd3, 16'h0000, 1'b0, 8'h02, 16'h0304, 6'h0C, 1'b0},
    {3'd0, 16'h8A55, 1'b0, 8'h00, 16'h0A55, 6'h02, 1'b0},
    {3'd4, 16'h0000, 1'b0, 8'h00, 16'h0A55, 6'h02, 1'b0},
    {3'd0, 16'h4000, 1'b0, 8'h00, 16'h0000, 6'h01, 1'b0},
    {3'd3, 16'h0000, 1'b0, 8'h05, 16'h0000, 6'h0C, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the strobe was taken
  task automatic do_op(input logic [2:0] op, input logic [15:0] w, input logic m5,
                       input logic [7:0] inc);
    ctl_wdata  = w;
    mode5_en   = m5;
    autoinc    = inc;
    ctl_wr     = (op == 3'd0);
    ctl_rd     = (op == 3'd1);
    data_wr    = (op == 3'd2);
    data_rd    = (op == 3'd3);
    fetch_done = (op == 3'd4);
    @(negedge clk);
    {ctl_wr, ctl_rd, data_wr, data_rd, fetch_done} = '0;
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R2 R3 R4 R8 command";
      3'd1:    return "R5 control read";
      3'd2:    return "R6 data write";
      3'd3:    return "R7 R8 data read";
      default: return "R7 prefetch";
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 addr", 32'(acc_addr), 32'h0);
    check("R9 code", 32'(acc_code), 32'h0);
    check("R9 pend/we/wq", {29'b0, cmd_pending, reg_we, wq_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic logic [50:0] v = TBL[i];
      do_op(v[50:48], v[47:32], v[31], v[30:23]);
      check(req_of(v[50:48]), {9'b0, acc_addr, acc_code, cmd_pending},
            {9'b0, v[22:7], v[6:1], v[0]});
    end

    // directed tests from a fresh reset
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 addr after second reset", 32'(acc_addr), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(3'd0, 16'h8F12, 1'b1, 8'h00);
    check("R1 reg_we pulse", 32'(reg_we), 32'h1);
    check("R1 reg index/value", {19'b0, reg_idx, reg_val}, {19'b0, 5'h0F, 8'h12});
    @(negedge clk);
    check("R1 reg_we one clock", 32'(reg_we), 32'h0);

    do_op(3'd0, 16'h4000, 1'b1, 8'h00);
    check("R4 pending set", 32'(cmd_pending), 32'h1);
    do_op(3'd0, 16'h8077, 1'b1, 8'h00);
    check("R4 second word no reg write", 32'(reg_we), 32'h0);
    check("R4 second word addr/code/pend", {9'b0, acc_addr, acc_code, cmd_pending},
          {9'b0, 16'hC000, 6'h1D, 1'b0});

    do_op(3'd0, 16'h8000, 1'b1, 8'h00);
    check("R3 code after reg write", 32'(acc_code), 32'h1E);
    do_op(3'd2, 16'h0000, 1'b1, 8'h02);
    check("R6 queue valid", 32'(wq_valid), 32'h1);
    check("R6 queue addr/code", {10'b0, wq_addr, wq_code}, {10'b0, 16'hC000, 6'h1F});
    check("R6 addr step", 32'(acc_addr), 32'hC002);
    @(negedge clk);
    check("R6 queue pulse one clock", 32'(wq_valid), 32'h0);

    // R10 control write beats data write in the same cycle
    ctl_wdata = 16'h4444; mode5_en = 1'b1; autoinc = 8'h02;
    ctl_wr = 1'b1; data_wr = 1'b1;
    @(negedge clk);
    {ctl_wr, data_wr} = '0;
    check("R10 ctl_wr wins", {9'b0, acc_addr, acc_code, cmd_pending},
          {9'b0, 16'hC444, 6'h1D, 1'b1});
    check("R10 no queue entry", 32'(wq_valid), 32'h0);

    // R10 control read beats data write
    ctl_rd = 1'b1; data_wr = 1'b1;
    @(negedge clk);
    {ctl_rd, data_wr} = '0;
    check("R10 R5 ctl_rd wins", {15'b0, acc_addr, cmd_pending}, {15'b0, 16'hC444, 1'b0});
    check("R10 no queue entry on read", 32'(wq_valid), 32'h0);

    do_op(3'd0, 16'h4000, 1'b1, 8'h00);
    do_op(3'd3, 16'h0000, 1'b1, 8'h02);
    check("R5 data read clears pending", 32'(cmd_pending), 32'h0);

    do_op(3'd0, 16'h7000, 1'b0, 8'h00);
    check("R4 mode 4 never pending", 32'(cmd_pending), 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule